// File: doc/BRIEF.md
# Overlay Output Control Stage

This block sits at the end of an on-screen overlay pipeline. A host writes two byte-wide control registers. Each pixel clock, upstream logic presents a "character pixel" strobe, a "window pixel" strobe and the pixel colour. From these the block drives registered RGB outputs and a fast-blanking output that tells the video mixer when to show overlay pixels in place of the picture.

The control registers cover five things: the master overlay enable, the polarity of the blanking output, a forced-blank override, and the choice of blanking on characters only or on characters and windows. They also set what the output pins do while the overlay is off, which is either to drive low or to float. High impedance is shown with one output-enable signal for the RGB group and one for the blanking pin. Two self-clearing command bits send one-cycle clear strobes to the window-enable registers and to the display registers. Three flags for the edge-effect and fade engines are stored and passed through.

Top module: `osd_out_ctl`

## Requirements
- R1: After reset, register A (wrSel/rdSel = 0) reads 0x00 and register B (select = 1) reads 0x01. rgbOe and blankOe are 0.
- R2: Register A bit 0 is the overlay enable. While it is 1, rgbOe and blankOe are 1 in the cycle after the pixel inputs are sampled. rgbOut equals pixRgb when chrActive or winActive is 1, and 0 otherwise.
- R3: While the enable is 0, register B bit 1 picks the idle pin state. When it is 1, rgbOe and blankOe are 1 and rgbOut and blankOut are 0. When it is 0, rgbOe and blankOe are 0.
- R4: Register B bit 0 sets the blanking polarity. When it is 1, blankOut is 1 while the blanking source is active. When it is 0, blankOut is the inverse of the source.
- R5: Register A bit 1 selects the blanking source. When it is 0, the source is chrActive OR winActive. When it is 1, the source is chrActive only.
- R6: While the overlay is enabled and register A bit 2 is 1, blankOut is 1 whatever the polarity and the pixel strobes.
- R7: Writing register A with bit 3 set makes winClrPulse 1 for exactly the next cycle. Writing with bit 4 set does the same for ramClrPulse. Each bit reads back 1 during its pulse cycle and 0 after it.
- R8: Register A bits 5, 6 and 7 are stored and drive edgeEn, shadowSel and fadeEn. They have no effect on the RGB or blanking outputs.
- R9: Register B bits 7 to 2 are reserved. They read back 0 whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = register A, 1 = register B |
| wrData | input | 8 | Write data |
| rdSel | input | 1 | Read source: 0 = register A, 1 = register B |
| rdData | output | 8 | Read data for the selected register |
| chrActive | input | 1 | Current pixel belongs to a character |
| winActive | input | 1 | Current pixel belongs to a window |
| pixRgb | input | 3*COLOR_W | Overlay pixel colour {R,G,B} |
| rgbOut | output | 3*COLOR_W | Registered RGB output |
| rgbOe | output | 1 | Output enable for the RGB pins |
| blankOut | output | 1 | Registered fast-blanking level |
| blankOe | output | 1 | Output enable for the blanking pin |
| winClrPulse | output | 1 | One-cycle clear strobe for window enables |
| ramClrPulse | output | 1 | One-cycle clear strobe for display registers |
| edgeEn | output | 1 | Border/shadow effect enable flag |
| shadowSel | output | 1 | 1 = shadow, 0 = border |
| fadeEn | output | 1 | Fade in/out enable flag |

## Verification
A wrong configuration bit inside the control register appears at rdData in the same cycle. It also appears on blankOut or on the output enables one cycle after the next pixel is sampled, because the output stage holds a single register. A clear bit that stays set shows as a strobe lasting two or more cycles, and as a readback of 1 two cycles after the write. The bench exercises every polarity, source and force combination and checks the outputs in the first cycle they can change.

// File: rtl/osd_out_pkg.sv
package osd_out_pkg;
  // Register A bit positions
  localparam int A_ENABLE = 0;
  localparam int A_CHARS_ONLY = 1;
  localparam int A_FORCE = 2;
  localparam int A_WIN_CLR = 3;
  localparam int A_RAM_CLR = 4;
  localparam int A_EDGE = 5;
  localparam int A_SHADOW = 6;
  localparam int A_FADE = 7;
  // Register B bit positions
  localparam int B_POL_POS = 0;
  localparam int B_IDLE_LOW = 1;

  typedef struct packed {
    logic enable;
    logic charsOnly;
    logic blankForce;
    logic polPos;
    logic idleLow;
  } out_cfg_t;

  typedef struct packed {
    logic winClr;
    logic ramClr;
  } clr_strobe_t;
endpackage

// File: rtl/osd_ctl_regs.sv
module osd_ctl_regs
  import osd_out_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output out_cfg_t          cfg,
  output clr_strobe_t       strobe,
  output logic              edgeEn,
  output logic              shadowSel,
  output logic              fadeEn
);
  logic enableQ, charsOnlyQ, forceQ, edgeQ, shadowQ, fadeQ;
  logic winClrQ, ramClrQ;
  logic polPosQ, idleLowQ;
  logic wrA, wrB;

  assign wrA = wrEn && !wrSel;
  assign wrB = wrEn && wrSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ    <= 1'b0;
      charsOnlyQ <= 1'b0;
      forceQ     <= 1'b0;
      edgeQ      <= 1'b0;
      shadowQ    <= 1'b0;
      fadeQ      <= 1'b0;
    end else if (wrA) begin
      enableQ    <= wrData[A_ENABLE];
      charsOnlyQ <= wrData[A_CHARS_ONLY];
      forceQ     <= wrData[A_FORCE];
      edgeQ      <= wrData[A_EDGE];
      shadowQ    <= wrData[A_SHADOW];
      fadeQ      <= wrData[A_FADE];
    end
  end

  // Self-clearing command bits: high for one cycle after the write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winClrQ <= 1'b0;
      ramClrQ <= 1'b0;
    end else begin
      winClrQ <= wrA && wrData[A_WIN_CLR];
      ramClrQ <= wrA && wrData[A_RAM_CLR];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polPosQ  <= 1'b1;
      idleLowQ <= 1'b0;
    end else if (wrB) begin
      polPosQ  <= wrData[B_POL_POS];
      idleLowQ <= wrData[B_IDLE_LOW];
    end
  end

  always_comb begin
    rdData = '0;
    if (!rdSel) begin
      rdData[A_ENABLE]     = enableQ;
      rdData[A_CHARS_ONLY] = charsOnlyQ;
      rdData[A_FORCE]      = forceQ;
      rdData[A_WIN_CLR]    = winClrQ;
      rdData[A_RAM_CLR]    = ramClrQ;
      rdData[A_EDGE]       = edgeQ;
      rdData[A_SHADOW]     = shadowQ;
      rdData[A_FADE]       = fadeQ;
    end else begin
      rdData[B_POL_POS]  = polPosQ;
      rdData[B_IDLE_LOW] = idleLowQ;
    end
  end

  assign cfg.enable     = enableQ;
  assign cfg.charsOnly  = charsOnlyQ;
  assign cfg.blankForce = forceQ;
  assign cfg.polPos     = polPosQ;
  assign cfg.idleLow    = idleLowQ;
  assign strobe.winClr  = winClrQ;
  assign strobe.ramClr  = ramClrQ;
  assign edgeEn    = edgeQ;
  assign shadowSel = shadowQ;
  assign fadeEn    = fadeQ;

  // R7
  win_pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.winClr && !(wrA && wrData[A_WIN_CLR])) |=> !strobe.winClr);
  // R7
  ram_pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ramClr && !(wrA && wrData[A_RAM_CLR])) |=> !strobe.ramClr);
  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSel |-> (rdData[DATA_W-1:2] == '0));
endmodule

// File: rtl/osd_out_path.sv
module osd_out_path
  import osd_out_pkg::*;
#(
  parameter int COLOR_W = 2,
  localparam int RGB_W = 3 * COLOR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  out_cfg_t         cfg,
  input  logic             chrActive,
  input  logic             winActive,
  input  logic [RGB_W-1:0] pixRgb,
  output logic [RGB_W-1:0] rgbOut,
  output logic             rgbOe,
  output logic             blankOut,
  output logic             blankOe
);
  logic srcOn, anyPix, blankLvl;

  assign anyPix = chrActive || winActive;
  assign srcOn  = cfg.charsOnly ? chrActive : anyPix;

  // Force overrides after polarity so the pin is high in both polarities
  always_comb begin
    if (cfg.blankForce) blankLvl = 1'b1;
    else if (cfg.polPos) blankLvl = srcOn;
    else blankLvl = !srcOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rgbOut   <= '0;
      rgbOe    <= 1'b0;
      blankOut <= 1'b0;
      blankOe  <= 1'b0;
    end else if (cfg.enable) begin
      rgbOut   <= anyPix ? pixRgb : '0;
      rgbOe    <= 1'b1;
      blankOut <= blankLvl;
      blankOe  <= 1'b1;
    end else begin
      rgbOut   <= '0;
      rgbOe    <= cfg.idleLow;
      blankOut <= 1'b0;
      blankOe  <= cfg.idleLow;
    end
  end

  // R2
  enabled_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfg.enable |=> (rgbOe && blankOe));
  // R3
  idle_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.enable && !cfg.idleLow) |=> (!rgbOe && !blankOe));
  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.enable && cfg.idleLow) |=> (rgbOe && blankOe && !blankOut && rgbOut == '0));
  // R6
  force_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && cfg.blankForce) |=> blankOut);
  // R5
  chars_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && !cfg.blankForce && cfg.charsOnly && cfg.polPos && !chrActive) |=> !blankOut);
endmodule

// File: rtl/osd_out_ctl.sv
module osd_out_ctl
  import osd_out_pkg::*;
#(
  parameter int COLOR_W = 2,
  localparam int DATA_W = 8,
  localparam int RGB_W = 3 * COLOR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              chrActive,
  input  logic              winActive,
  input  logic [RGB_W-1:0]  pixRgb,
  output logic [RGB_W-1:0]  rgbOut,
  output logic              rgbOe,
  output logic              blankOut,
  output logic              blankOe,
  output logic              winClrPulse,
  output logic              ramClrPulse,
  output logic              edgeEn,
  output logic              shadowSel,
  output logic              fadeEn
);
  out_cfg_t    cfg;
  clr_strobe_t strobe;

  osd_ctl_regs #(.DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .cfg(cfg), .strobe(strobe),
    .edgeEn(edgeEn), .shadowSel(shadowSel), .fadeEn(fadeEn)
  );

  osd_out_path #(.COLOR_W(COLOR_W)) uPath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .chrActive(chrActive),
    .winActive(winActive), .pixRgb(pixRgb), .rgbOut(rgbOut), .rgbOe(rgbOe),
    .blankOut(blankOut), .blankOe(blankOe)
  );

  assign winClrPulse = strobe.winClr;
  assign ramClrPulse = strobe.ramClr;
endmodule

// File: tb/tb_osd_out_ctl.sv
module tb_osd_out_ctl;
  localparam int COLOR_W = 2;
  localparam int RGB_W = 3 * COLOR_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0, rdSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic chrActive = 1'b0, winActive = 1'b0;
  logic [RGB_W-1:0] pixRgb = '0;
  logic [RGB_W-1:0] rgbOut;
  logic rgbOe, blankOut, blankOe, winClrPulse, ramClrPulse;
  logic edgeEn, shadowSel, fadeEn;
  int total = 0, bad = 0;
  bit done = 1'b0;

  osd_out_ctl #(.COLOR_W(COLOR_W)) dut (.*);

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic sel, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Drive a pixel, output seen after the next rising edge
  task automatic pixel(logic c, logic w, logic [RGB_W-1:0] p);
    chrActive = c; winActive = w; pixRgb = p;
    @(negedge clk);
  endtask

  task automatic testReset();
    rdSel = 1'b0; #1; check("R1 regA", rdData, 8'h00);
    rdSel = 1'b1; #1; check("R1 regB", rdData, 8'h01);
    check("R1 oe", {rgbOe, blankOe}, 2'b00);
  endtask

  task automatic testIdle();
    pixel(1, 1, 6'h2A);
    check("R3 float", {rgbOe, blankOe}, 2'b00);
    writeReg(1, 8'h03);
    pixel(1, 1, 6'h2A);
    check("R3 drive low", {rgbOe, blankOe, blankOut, 26'(rgbOut)}, {3'b110, 26'h0});
  endtask

  task automatic testEnable();
    writeReg(1, 8'h01);
    writeReg(0, 8'h01);
    pixel(1, 0, 6'h15);
    check("R2 chr rgb", {rgbOe, blankOe, 26'(rgbOut)}, {2'b11, 26'h15});
    pixel(0, 1, 6'h33);
    check("R2 win rgb", rgbOut, 6'h33);
    pixel(0, 0, 6'h3F);
    check("R2 idle rgb", rgbOut, 6'h00);
  endtask

  task automatic testBlank();
    for (int pol = 0; pol < 2; pol++) begin
      for (int co = 0; co < 2; co++) begin
        writeReg(1, 8'(pol));
        writeReg(0, 8'h01 | 8'(co << 1));
        for (int v = 0; v < 4; v++) begin
          logic c, w, src;
          c = v[0]; w = v[1];
          src = co ? c : (c | w);
          pixel(c, w, 6'h01);
          check(co ? "R5 R4 chars only" : "R5 R4 chars+win", blankOut, pol ? src : !src);
        end
        writeReg(0, 8'h05 | 8'(co << 1));
        pixel(0, 0, 6'h0);
        check("R6 force idle pixel", blankOut, 1'b1);
        pixel(1, 1, 6'h0);
        check("R6 force active pixel", blankOut, 1'b1);
      end
    end
  endtask

  task automatic testClear();
    rdSel = 1'b0;
    writeReg(0, 8'h09);
    check("R7 win pulse", {winClrPulse, ramClrPulse}, 2'b10);
    check("R7 win readback during", rdData[3], 1'b1);
    @(negedge clk);
    check("R7 win pulse ended", {winClrPulse, ramClrPulse}, 2'b00);
    check("R7 readback zero", rdData, 8'h01);
    writeReg(0, 8'h11);
    check("R7 ram pulse", {winClrPulse, ramClrPulse}, 2'b01);
    @(negedge clk);
    check("R7 ram pulse ended", ramClrPulse, 1'b0);
  endtask

  task automatic testFlags();
    writeReg(1, 8'h01);
    writeReg(0, 8'hE1);
    check("R8 flags", {edgeEn, shadowSel, fadeEn}, 3'b111);
    pixel(0, 0, 6'h3F);
    check("R8 no effect blank", {blankOut, 26'(rgbOut)}, 27'h0);
    writeReg(0, 8'hA1);
    check("R8 shadow clear", {edgeEn, shadowSel, fadeEn}, 3'b101);
    writeReg(1, 8'hFD);
    rdSel = 1'b1; #1;
    check("R9 reserved", rdData, 8'h01);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    testEnable();
    testBlank();
    testClear();
    testFlags();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule